// File: doc/BRIEF.md
# Masked Beam Position Comparator

This block decides, once per colour-clock tick, whether the raster beam has reached the position named by a two-word wait or conditional-skip instruction. The caller presents the beam's line and horizontal counts, the two instruction words and a flag that says whether the blitter has finished. It also raises a compare-active strobe while such an instruction is pending. The block returns a single registered "satisfied" flag.

The target position and a per-bit enable vector come from the instruction words. Each disabled bit is cleared on both the beam side and the target side. An unsigned greater-or-equal test then runs on the joined line/horizontal value. The top bit of the line count has no enable bit and always takes part. A qualifier bit in the second word can also require the blitter to be idle. The result register changes only on a tick. It reads zero whenever no compare is active, so an old result cannot carry over into the next instruction. The block does not fetch instructions and does not count the beam.

Top module: `beam_cmp_top`

## Requirements
- R1: After reset, `sat_q` is 0.
- R2: With every enable bit set and word2[15]=1, a tick sets `sat_q` to 1 exactly when {vpos[7:0], hpos[8:2]} >= {word1[15:8], word1[7:1]}, compared as unsigned 15-bit values. Otherwise the tick sets it to 0.
- R3: word2[14:8] enable line bits 6..0 and word2[7:1] enable hpos bits 8..2. A bit with enable 0 is cleared on both the beam side and the target side before the compare, so that bit always counts as met.
- R4: Line bit 7 has no enable bit and is always compared. With word2[14:1]=0, vpos[7]=0 and word1[15]=1, a tick gives 0.
- R5: hpos[1:0], word1[0] and word2[0] have no effect on the result.
- R6: When word2[15]=0, the result also requires `blit_done`=1. A tick with `blit_done`=0 gives 0.
- R7: When word2[15]=1, `blit_done` has no effect on the result.
- R8: A tick with `cmp_en`=0 sets `sat_q` to 0.
- R9: `sat_q` changes only on a clock edge where `cc_tick`=1. Otherwise it holds its value.
- R10: The target word1=16'hFFFF with full enables never passes while hpos <= 9'h1C5, which is the largest horizontal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cc_tick | input | 1 | Colour-clock strobe; the result register updates only when this is high |
| cmp_en | input | 1 | A wait or skip compare is pending |
| vpos | input | 8 | Low 8 bits of the beam line count |
| hpos | input | 9 | Horizontal beam count; bits 8..2 are compared |
| word1 | input | 16 | Instruction word 1: line target [15:8], horizontal target [7:1] |
| word2 | input | 16 | Instruction word 2: blitter-ignore [15], line enables [14:8], horizontal enables [7:1] |
| blit_done | input | 1 | The blitter has finished |
| sat_q | output | 1 | Registered condition-satisfied flag |

## Verification
The only state is the result register, so any internal fault shows on `sat_q` at the first tick after the faulty condition. A wrong mask or bit mapping gives a flag that differs from the unsigned compare at that tick. A missing hold or clear shows one edge later: the flag stays set across a tick with `cmp_en` low, or it moves on an edge without `cc_tick`. Random line, horizontal and enable patterns, with `cc_tick` gaps mixed in, make each such fault visible within a few cycles.

// File: rtl/bcmp_pkg.sv
package bcmp_pkg;

    parameter int V_W      = 8;
    parameter int H_W      = 9;
    parameter int H_DROP   = 2;
    parameter int WORD_W   = 16;

    localparam int HF_W    = H_W - H_DROP;
    localparam int KEY_W   = V_W + HF_W;

    typedef struct packed {
        logic [KEY_W-1:0] pos;
        logic [KEY_W-1:0] en;
        logic             need_blit;
    } target_t;

    typedef struct packed {
        logic sat;
    } state_t;

endpackage

// File: rtl/bcmp_decode.sv
module bcmp_decode
    import bcmp_pkg::*;
(
    input  logic [WORD_W-1:0] word1,
    input  logic [WORD_W-1:0] word2,
    output target_t           tgt
);

    localparam int VEN_W = V_W - 1;

    logic [1:0] unused_lsbs;

    // word1[15:1] holds the joined line/horizontal target
    // word2[14:1] holds enables for every compared bit except line bit 7
    always_comb begin
        tgt.pos       = word1[WORD_W-1 -: KEY_W];
        tgt.en        = {1'b1, word2[WORD_W-2 -: (VEN_W + HF_W)]};
        tgt.need_blit = ~word2[WORD_W-1];
    end

    assign unused_lsbs = {word1[0], word2[0]};

endmodule

// File: rtl/bcmp_ge.sv
module bcmp_ge #(
    parameter int W = 15
) (
    input  logic [W-1:0] beam,
    input  logic [W-1:0] target,
    input  logic [W-1:0] en,
    output logic         ge
);

    logic [W-1:0] beam_m;
    logic [W-1:0] tgt_m;
    logic [W:0]   eq_acc;
    logic [W:0]   gt_acc;

    assign eq_acc[W] = 1'b1;
    assign gt_acc[W] = 1'b0;

    // Masking is done per bit; the magnitude chain then runs from the MSB down
    for (genvar i = W - 1; i >= 0; i--) begin : g_bit
        assign beam_m[i] = beam[i] & en[i];
        assign tgt_m[i]  = target[i] & en[i];
        assign gt_acc[i] = gt_acc[i+1] | (eq_acc[i+1] & beam_m[i] & ~tgt_m[i]);
        assign eq_acc[i] = eq_acc[i+1] & ~(beam_m[i] ^ tgt_m[i]);
    end

    assign ge = gt_acc[0] | eq_acc[0];

endmodule

// File: rtl/beam_cmp_top.sv
module beam_cmp_top
    import bcmp_pkg::*;
#(
    parameter logic [H_W-1:0] H_LIMIT = 9'h1C5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cc_tick,
    input  logic              cmp_en,
    input  logic [V_W-1:0]    vpos,
    input  logic [H_W-1:0]    hpos,
    input  logic [WORD_W-1:0] word1,
    input  logic [WORD_W-1:0] word2,
    input  logic              blit_done,
    output logic              sat_q
);

    target_t          tgt;
    logic [KEY_W-1:0] beam_key;
    logic             pos_ge;
    logic             blit_ok;
    logic [H_DROP-1:0] unused_hlow;
    state_t           st_d;
    state_t           st_q;

    bcmp_decode u_decode (
        .word1 (word1),
        .word2 (word2),
        .tgt   (tgt)
    );

    assign beam_key    = {vpos, hpos[H_W-1:H_DROP]};
    assign unused_hlow = hpos[H_DROP-1:0];

    bcmp_ge #(.W(KEY_W)) u_ge (
        .beam   (beam_key),
        .target (tgt.pos),
        .en     (tgt.en),
        .ge     (pos_ge)
    );

    assign blit_ok = ~tgt.need_blit | blit_done;

    always_comb begin
        st_d = st_q;
        if (cc_tick) begin
            st_d.sat = cmp_en & pos_ge & blit_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sat_q = st_q.sat;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_tick && !cmp_en) |=> !sat_q);  // R8
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_tick |=> $stable(sat_q));  // R9
    AST_BLIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_tick && !word2[WORD_W-1] && !blit_done) |=> !sat_q);  // R6
    AST_LINE_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_tick && !vpos[V_W-1] && word1[WORD_W-1]) |=> !sat_q);  // R4
    AST_NEVER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_tick && word1 == 16'hFFFF && word2[14:1] == 14'h3FFF && hpos <= H_LIMIT)
        |=> !sat_q);  // R10

endmodule

// File: tb/beam_cmp_top_tb_top.sv
module beam_cmp_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cc_tick = 1'b0;
    logic        cmp_en = 1'b0;
    logic [7:0]  vpos = '0;
    logic [8:0]  hpos = '0;
    logic [15:0] word1 = '0;
    logic [15:0] word2 = '0;
    logic        blit_done = 1'b0;
    logic        sat_q;

    int checks = 0;
    int errors = 0;
    bit model_q = 1'b0;

    always #2 clk = ~clk;

    beam_cmp_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cc_tick   (cc_tick),
        .cmp_en    (cmp_en),
        .vpos      (vpos),
        .hpos      (hpos),
        .word1     (word1),
        .word2     (word2),
        .blit_done (blit_done),
        .sat_q     (sat_q)
    );

    function automatic bit ref_sat(input logic [7:0] v, input logic [8:0] h,
                                   input logic [15:0] w1, input logic [15:0] w2,
                                   input logic bd, input logic en);
        int beam, tgt, msk;
        beam = (int'(v) << 7) | ((int'(h) >> 2) & 'h7F);
        tgt  = (int'(w1) >> 1) & 'h7FFF;
        msk  = 'h4000 | ((int'(w2) >> 1) & 'h3FFF);
        return en && ((beam & msk) >= (tgt & msk)) && (w2[15] || bd);
    endfunction

    task automatic check(input string req, input bit exp);
        checks++;
        if (sat_q !== exp) begin
            errors++;
            $display("FAIL %s: sat_q=%0b expected=%0b", req, sat_q, exp);
        end
    endtask

    task automatic step(input string req, input logic [7:0] v, input logic [8:0] h,
                        input logic [15:0] w1, input logic [15:0] w2,
                        input logic bd, input logic en, input logic tk);
        vpos = v; hpos = h; word1 = w1; word2 = w2;
        blit_done = bd; cmp_en = en; cc_tick = tk;
        if (tk) model_q = ref_sat(v, h, w1, w2, bd, en);
        @(posedge clk);
        @(negedge clk);
        check(req, model_q);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        logic [8:0] hr;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R1", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0);

        // R2: line 150 wait, horizontal masked
        step("R2", 8'h95, 9'h100, 16'h9601, 16'hFF00, 1'b0, 1'b1, 1'b1);
        step("R2", 8'h96, 9'h000, 16'h9601, 16'hFF00, 1'b0, 1'b1, 1'b1);
        step("R2", 8'h40, 9'h0F0, 16'h403D, 16'hFFFE, 1'b0, 1'b1, 1'b1);
        step("R2", 8'h40, 9'h0EF, 16'h403D, 16'hFFFE, 1'b0, 1'b1, 1'b1);
        // R3: low line bits masked off; only bit 7 left
        step("R3", 8'h01, 9'h000, 16'h7F01, 16'h8000, 1'b0, 1'b1, 1'b1);
        step("R3", 8'h10, 9'h000, 16'h3001, 16'hB000, 1'b0, 1'b1, 1'b1);
        step("R3", 8'h20, 9'h000, 16'h3001, 16'hB000, 1'b0, 1'b1, 1'b1);
        // R4: line bit 7 cannot be masked
        step("R4", 8'h7F, 9'h1C5, 16'h8001, 16'h8000, 1'b1, 1'b1, 1'b1);
        step("R4", 8'h80, 9'h000, 16'h8001, 16'h8000, 1'b1, 1'b1, 1'b1);
        // R5: hpos[1:0], word1[0], word2[0] ignored
        step("R5", 8'h00, 9'h043, 16'h0021, 16'hFFFE, 1'b0, 1'b1, 1'b1);
        step("R5", 8'h00, 9'h040, 16'h0020, 16'hFFFF, 1'b0, 1'b1, 1'b1);
        step("R5", 8'h00, 9'h03F, 16'h0021, 16'hFFFF, 1'b0, 1'b1, 1'b1);
        // R6 / R7: blitter qualifier
        step("R6", 8'hA0, 9'h100, 16'h1001, 16'h7FFE, 1'b0, 1'b1, 1'b1);
        step("R6", 8'hA0, 9'h100, 16'h1001, 16'h7FFE, 1'b1, 1'b1, 1'b1);
        step("R7", 8'hA0, 9'h100, 16'h1001, 16'hFFFE, 1'b0, 1'b1, 1'b1);
        // R9: no tick holds the set result though inputs now fail
        step("R9", 8'h00, 9'h000, 16'hFFFF, 16'hFFFE, 1'b0, 1'b1, 1'b0);
        // R8: compare inactive clears
        step("R8", 8'hFF, 9'h1C5, 16'h0001, 16'hFFFE, 1'b1, 1'b0, 1'b1);
        step("R9", 8'hFF, 9'h1C5, 16'h0001, 16'hFFFE, 1'b1, 1'b1, 1'b0);
        // R10: end-of-list target never reached
        step("R10", 8'hFF, 9'h1C5, 16'hFFFF, 16'hFFFE, 1'b1, 1'b1, 1'b1);
        step("R10", 8'hFF, 9'h1C7, 16'hFFFF, 16'hFFFE, 1'b1, 1'b1, 1'b1);

        for (int n = 0; n < 400; n++) begin
            hr = 9'($urandom_range(0, 'h1C5));
            step("R2", 8'($urandom), hr, 16'($urandom),
                 ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'hFFFE,
                 1'($urandom), ($urandom_range(0, 7) != 0),
                 ($urandom_range(0, 4) != 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule